// File: doc/BRIEF.md
# Dual-Port RAM with Address-Collision Arbiter

This block is a synchronous, true dual-port memory with a left and a right port on one shared clock. Each port has its own chip enable, write strobe, output enable, upper and lower byte selects, address and 16-bit write and read data. Either port can read or write any word at any time. The byte selects pick which half of the word is written or shown.

Alongside the array sits a collision arbiter. A collision exists when both ports are enabled on the same address, whatever their directions. In master mode the arbiter grants the word to the port that was there first and raises a busy flag on the other port, one side only. That port's writes are dropped for as long as the collision lasts. In slave mode the arbiter stays silent, and each port's busy input acts as a write inhibit for that port. This lets a wide array of several such blocks follow the decision made by one master.

The default address width keeps the elaborated array small. Setting `ADDR_W` to 14 gives the full 16K-word array.

Top module: `dpram_collide`

## Requirements
- R1: The array holds 2^ADDR_W words of 16 bits. A word written through either port is read back unchanged through either port.
- R2: Lower select `*_lb` governs bits 7..0 and upper select `*_ub` governs bits 15..8. A write changes only the selected lanes. On a read, an unselected lane reads as zero.
- R3: While a port's chip enable is low, that port writes nothing, and its read data in the following cycle is zero.
- R4: A read cycle (chip enable high, write low, output enable high) presents the addressed word on the read data in the next cycle. With output enable low, the read data is zero.
- R5: A collision requires both chip enables high and equal addresses; write direction does not matter. In master mode the busy output of exactly one port goes high in the cycle after the first colliding cycle. Both busy outputs are never high together.
- R6: If one port held its enable and address from the previous cycle and the other port newly arrives at that address, the newcomer's busy output is raised.
- R7: If both ports arrive at the colliding address in the same cycle, the right port is flagged busy. The choice holds while the collision continues.
- R8: In master mode, a write from the flagged port is suppressed in every colliding cycle, including the first one. The winning port's write proceeds.
- R9: Busy drops in the cycle after the addresses differ or either enable goes low. From then on, a write from the formerly flagged port is performed.
- R10: In slave mode, both busy outputs stay low. A high busy input blocks that port's writes and a low one lets them through. In master mode the busy inputs have no effect.
- R11: After reset, both busy outputs and both read data buses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| master_i | input | 1 | 1 = master (arbitrate and drive busy), 0 = slave (busy is an inhibit input) |
| l_ce | input | 1 | Left chip enable, active high |
| l_we | input | 1 | Left write strobe (1 = write, 0 = read) |
| l_oe | input | 1 | Left output enable |
| l_ub | input | 1 | Left upper byte select (bits 15..8) |
| l_lb | input | 1 | Left lower byte select (bits 7..0) |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data |
| l_busy_i | input | 1 | Left write inhibit in slave mode |
| l_busy_o | output | 1 | Left busy flag in master mode |
| r_ce | input | 1 | Right chip enable, active high |
| r_we | input | 1 | Right write strobe |
| r_oe | input | 1 | Right output enable |
| r_ub | input | 1 | Right upper byte select |
| r_lb | input | 1 | Right lower byte select |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data |
| r_busy_i | input | 1 | Right write inhibit in slave mode |
| r_busy_o | output | 1 | Right busy flag in master mode |

## Verification
On every cycle, the assertions check the following:
- the busy outputs are exclusive;
- the newcomer and same-cycle tie rules decide which side is flagged;
- the loser stays flagged for the whole collision;
- busy is released once the match ends;
- both flags stay quiet in slave mode;
- the flagged port's write inhibit is held;
- a port's read data is zero when that port did not read.

Only the bench scenarios can show what actually lands in the array. That covers byte-lane merging, suppressed loser writes against completed winner writes, the write that goes through after release, and slave-mode inhibit. Each of these is checked by reading the stored word back afterwards.

// File: rtl/dpram_collide_pkg.sv
package dpram_collide_pkg;
  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } side_e;
endpackage

// File: rtl/dpram_collide_arbiter.sv
module dpram_collide_arbiter
  import dpram_collide_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_i,
  input  logic              ce_l,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic              ext_inh_l,
  input  logic              ce_r,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic              ext_inh_r,
  output logic              inh_l,
  output logic              inh_r,
  output logic              busy_l,
  output logic              busy_r
);
  logic              prev_ce_l, prev_ce_r;
  logic [ADDR_W-1:0] prev_addr_l, prev_addr_r;
  logic              coll_q;
  side_e             loser_q, loser_c;
  logic              match, new_l, new_r;

  // a request is new if its enable just rose or its address moved
  assign match = ce_l && ce_r && (addr_l == addr_r);
  assign new_l = ce_l && (!prev_ce_l || (addr_l != prev_addr_l));
  assign new_r = ce_r && (!prev_ce_r || (addr_r != prev_addr_r));

  always_comb begin
    if (coll_q)               loser_c = loser_q;
    else if (new_l && !new_r) loser_c = SIDE_LEFT;
    else                      loser_c = SIDE_RIGHT;   // tie: left has priority
  end

  assign inh_l = master_i ? (match && loser_c == SIDE_LEFT)  : ext_inh_l;
  assign inh_r = master_i ? (match && loser_c == SIDE_RIGHT) : ext_inh_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_ce_l   <= 1'b0;
      prev_ce_r   <= 1'b0;
      prev_addr_l <= '0;
      prev_addr_r <= '0;
      coll_q      <= 1'b0;
      loser_q     <= SIDE_RIGHT;
      busy_l      <= 1'b0;
      busy_r      <= 1'b0;
    end else begin
      prev_ce_l   <= ce_l;
      prev_ce_r   <= ce_r;
      prev_addr_l <= addr_l;
      prev_addr_r <= addr_r;
      coll_q      <= master_i && match;
      loser_q     <= loser_c;
      busy_l      <= master_i && match && (loser_c == SIDE_LEFT);
      busy_r      <= master_i && match && (loser_c == SIDE_RIGHT);
    end
  end

  p_busy_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
    !(busy_l && busy_r));
  p_newcomer_left_r6: assert property (@(posedge clk) disable iff (rst)
    master_i && match && !coll_q && new_l && !new_r |=> busy_l);
  p_newcomer_right_r6: assert property (@(posedge clk) disable iff (rst)
    master_i && match && !coll_q && new_r && !new_l |=> busy_r);
  p_tie_right_r7: assert property (@(posedge clk) disable iff (rst)
    master_i && match && !coll_q && new_l && new_r |=> busy_r);
  p_hold_right_r7: assert property (@(posedge clk) disable iff (rst)
    busy_r && master_i && match |=> busy_r);
  p_hold_left_r7: assert property (@(posedge clk) disable iff (rst)
    busy_l && master_i && match |=> busy_l);
  p_loser_blocked_r8: assert property (@(posedge clk) disable iff (rst)
    master_i && match && (busy_l || busy_r) |-> (inh_l == busy_l) && (inh_r == busy_r));
  p_release_r9: assert property (@(posedge clk) disable iff (rst)
    !match |=> !busy_l && !busy_r);
  p_slave_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !master_i |=> !busy_l && !busy_r);
endmodule

// File: rtl/dpram_collide_lane_ram.sv
module dpram_collide_lane_ram #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              en_a,
  input  logic              wen_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [LANE_W-1:0] din_a,
  output logic [LANE_W-1:0] dout_a,
  input  logic              en_b,
  input  logic              wen_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [LANE_W-1:0] din_b,
  output logic [LANE_W-1:0] dout_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  // reads return the word held before this edge's writes
  always_ff @(posedge clk) begin
    if (wen_a) mem[addr_a] <= din_a;
    if (wen_b) mem[addr_b] <= din_b;
    if (en_a)  dout_a <= mem[addr_a];
    if (en_b)  dout_b <= mem[addr_b];
  end
endmodule

// File: rtl/dpram_collide_readout.sv
module dpram_collide_readout #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ce,
  input  logic                    we,
  input  logic                    oe,
  input  logic [LANES-1:0]        sel,
  input  logic [LANES*LANE_W-1:0] raw,
  output logic [LANES*LANE_W-1:0] rdata
);
  logic [LANES-1:0] show_q;

  always_ff @(posedge clk) begin
    if (rst) show_q <= '0;
    else     show_q <= (ce && !we && oe) ? sel : '0;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rdata[g*LANE_W +: LANE_W] = show_q[g] ? raw[g*LANE_W +: LANE_W] : '0;
  end

  p_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !(ce && !we && oe) |=> rdata == '0);
endmodule

// File: rtl/dpram_collide.sv
module dpram_collide #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  master_i,
  input  logic                  l_ce,
  input  logic                  l_we,
  input  logic                  l_oe,
  input  logic                  l_ub,
  input  logic                  l_lb,
  input  logic [ADDR_W-1:0]     l_addr,
  input  logic [2*LANE_W-1:0]   l_wdata,
  output logic [2*LANE_W-1:0]   l_rdata,
  input  logic                  l_busy_i,
  output logic                  l_busy_o,
  input  logic                  r_ce,
  input  logic                  r_we,
  input  logic                  r_oe,
  input  logic                  r_ub,
  input  logic                  r_lb,
  input  logic [ADDR_W-1:0]     r_addr,
  input  logic [2*LANE_W-1:0]   r_wdata,
  output logic [2*LANE_W-1:0]   r_rdata,
  input  logic                  r_busy_i,
  output logic                  r_busy_o
);
  localparam int LANES  = 2;
  localparam int DATA_W = LANES * LANE_W;

  logic              inh_l, inh_r;
  logic [LANES-1:0]  sel_l, sel_r;
  logic [DATA_W-1:0] raw_l, raw_r;

  assign sel_l = {l_ub, l_lb};
  assign sel_r = {r_ub, r_lb};

  dpram_collide_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk(clk), .rst(rst), .master_i(master_i),
    .ce_l(l_ce), .addr_l(l_addr), .ext_inh_l(l_busy_i),
    .ce_r(r_ce), .addr_r(r_addr), .ext_inh_r(r_busy_i),
    .inh_l(inh_l), .inh_r(inh_r), .busy_l(l_busy_o), .busy_r(r_busy_o)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dpram_collide_lane_ram #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_ram (
      .clk(clk),
      .en_a(l_ce), .wen_a(l_ce && l_we && !inh_l && sel_l[g]),
      .addr_a(l_addr), .din_a(l_wdata[g*LANE_W +: LANE_W]),
      .dout_a(raw_l[g*LANE_W +: LANE_W]),
      .en_b(r_ce), .wen_b(r_ce && r_we && !inh_r && sel_r[g]),
      .addr_b(r_addr), .din_b(r_wdata[g*LANE_W +: LANE_W]),
      .dout_b(raw_r[g*LANE_W +: LANE_W])
    );
  end

  dpram_collide_readout #(.LANES(LANES), .LANE_W(LANE_W)) u_rd_l (
    .clk(clk), .rst(rst), .ce(l_ce), .we(l_we), .oe(l_oe),
    .sel(sel_l), .raw(raw_l), .rdata(l_rdata)
  );

  dpram_collide_readout #(.LANES(LANES), .LANE_W(LANE_W)) u_rd_r (
    .clk(clk), .rst(rst), .ce(r_ce), .we(r_we), .oe(r_oe),
    .sel(sel_r), .raw(raw_r), .rdata(r_rdata)
  );
endmodule

// File: tb/dpram_collide_bench.sv
module dpram_collide_bench;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic master = 1'b1;
  logic l_ce = 0, l_we = 0, l_oe = 0, l_ub = 0, l_lb = 0, l_bi = 0;
  logic r_ce = 0, r_we = 0, r_oe = 0, r_ub = 0, r_lb = 0, r_bi = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [15:0] l_wd = '0, r_wd = '0, l_rd, r_rd;
  logic l_bo, r_bo;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dpram_collide u_dpram_collide (
    .clk(clk), .rst(rst), .master_i(master),
    .l_ce(l_ce), .l_we(l_we), .l_oe(l_oe), .l_ub(l_ub), .l_lb(l_lb),
    .l_addr(l_addr), .l_wdata(l_wd), .l_rdata(l_rd), .l_busy_i(l_bi), .l_busy_o(l_bo),
    .r_ce(r_ce), .r_we(r_we), .r_oe(r_oe), .r_ub(r_ub), .r_lb(r_lb),
    .r_addr(r_addr), .r_wdata(r_wd), .r_rdata(r_rd), .r_busy_i(r_bi), .r_busy_o(r_bo)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    l_ce = 0; l_we = 0; l_oe = 0; l_ub = 0; l_lb = 0;
    r_ce = 0; r_we = 0; r_oe = 0; r_ub = 0; r_lb = 0;
  endtask

  task automatic drv_l(logic we, logic oe, logic ub, logic lb, logic [AW-1:0] a, logic [15:0] d);
    l_ce = 1; l_we = we; l_oe = oe; l_ub = ub; l_lb = lb; l_addr = a; l_wd = d;
  endtask

  task automatic drv_r(logic we, logic oe, logic ub, logic lb, logic [AW-1:0] a, logic [15:0] d);
    r_ce = 1; r_we = we; r_oe = oe; r_ub = ub; r_lb = lb; r_addr = a; r_wd = d;
  endtask

  task automatic write_l(logic [AW-1:0] a, logic [15:0] d);
    idle(); drv_l(1, 0, 1, 1, a, d); tick(); idle();
  endtask

  task automatic read_l(string req, logic [AW-1:0] a, logic [15:0] exp);
    idle(); drv_l(0, 1, 1, 1, a, '0); tick(); chk(req, l_rd, exp); idle();
  endtask

  task automatic read_r(string req, logic [AW-1:0] a, logic [15:0] exp);
    idle(); drv_r(0, 1, 1, 1, a, '0); tick(); chk(req, r_rd, exp); idle();
  endtask

  task automatic t_reset();
    idle(); tick();
    chk("R11 busy after reset", {l_bo, r_bo}, 0);
    chk("R11 rdata after reset", {l_rd, r_rd}, 0);
  endtask

  task automatic t_basic_lanes();
    write_l(5, 16'h1234);
    read_r("R1 cross-port read", 5, 16'h1234);
    idle(); drv_l(1, 0, 0, 1, 5, 16'hABCD); tick(); idle();
    read_l("R2 lower lane merged", 5, 16'h12CD);
    idle(); drv_l(0, 1, 1, 0, 5, '0); tick(); chk("R2 upper only read", l_rd, 16'h1200);
    idle(); drv_l(0, 1, 0, 1, 5, '0); tick(); chk("R2 lower only read", l_rd, 16'h00CD);
    idle();
  endtask

  task automatic t_enables();
    idle(); drv_l(0, 0, 1, 1, 5, '0); tick(); chk("R4 oe low reads zero", l_rd, 0);
    idle(); l_addr = 5; l_we = 1; l_ub = 1; l_lb = 1; l_wd = 16'hFFFF; tick();
    chk("R3 ce low reads zero", l_rd, 0);
    idle();
    read_l("R3 ce low write ignored", 5, 16'h12CD);
  endtask

  task automatic t_left_first();
    write_l(9, 16'h1111);
    idle(); drv_l(0, 1, 1, 1, 9, '0); tick();
    drv_r(1, 0, 1, 1, 9, 16'h7777); tick();
    chk("R6 newcomer right busy", {l_bo, r_bo}, 2'b01);
    tick();
    chk("R8 loser still flagged", {l_bo, r_bo}, 2'b01);
    idle(); tick();
    chk("R9 busy released", {l_bo, r_bo}, 0);
    read_l("R8 loser write dropped", 9, 16'h1111);
  endtask

  task automatic t_right_first();
    idle(); drv_r(1, 0, 1, 1, 30, 16'h0A0A); tick(); idle();
    drv_r(0, 1, 1, 1, 30, '0); tick();
    drv_l(1, 0, 1, 1, 30, 16'h5555); tick();
    chk("R6 newcomer left busy", {l_bo, r_bo}, 2'b10);
    idle(); tick();
    read_r("R8 left loser write dropped", 30, 16'h0A0A);
  endtask

  task automatic t_tie_release();
    idle(); tick();
    drv_l(0, 1, 1, 1, 12, '0); drv_r(0, 1, 1, 1, 12, '0); tick();
    chk("R7 tie flags right", {l_bo, r_bo}, 2'b01);
    drv_l(1, 0, 1, 1, 12, 16'h2222); drv_r(1, 0, 1, 1, 12, 16'h3333); tick();
    chk("R7 choice held", {l_bo, r_bo}, 2'b01);
    l_ce = 0; l_we = 0; drv_r(1, 0, 1, 1, 12, 16'h4444); tick();
    chk("R9 busy drops after left leaves", {l_bo, r_bo}, 0);
    idle();
    read_l("R9 write after release lands", 12, 16'h4444);
    idle(); drv_l(1, 0, 1, 1, 12, 16'h2222); drv_r(1, 0, 1, 1, 12, 16'h3333); tick();
    chk("R5 both writes collide", {l_bo, r_bo}, 2'b01);
    idle(); tick();
    read_r("R8 winner write lands", 12, 16'h2222);
    idle(); drv_l(0, 1, 1, 1, 40, '0); r_addr = 40; tick();
    chk("R5 one enable low no busy", {l_bo, r_bo}, 0);
    drv_r(0, 1, 1, 1, 41, '0); tick();
    chk("R5 different addr no busy", {l_bo, r_bo}, 0);
    idle();
  endtask

  task automatic t_slave();
    write_l(20, 16'h0101);
    master = 0;
    idle(); drv_l(0, 1, 1, 1, 20, '0); drv_r(0, 1, 1, 1, 20, '0); tick();
    chk("R10 slave busy outputs low", {l_bo, r_bo}, 0);
    idle(); l_bi = 1; drv_l(1, 0, 1, 1, 20, 16'hAAAA); tick(); l_bi = 0; idle();
    read_l("R10 inhibited left write", 20, 16'h0101);
    write_l(20, 16'hAAAA);
    read_l("R10 uninhibited write", 20, 16'hAAAA);
    idle(); r_bi = 1; drv_r(1, 0, 1, 1, 20, 16'hCCCC); tick(); r_bi = 0; idle();
    read_r("R10 inhibited right write", 20, 16'hAAAA);
    master = 1;
    idle(); l_bi = 1; drv_l(1, 0, 1, 1, 20, 16'hBBBB); tick(); idle();
    read_l("R10 busy input ignored in master", 20, 16'hBBBB);
    l_bi = 0;
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    tick(); tick(); tick();
    rst = 0;
    t_reset();
    t_basic_lanes();
    t_enables();
    t_left_first();
    t_right_first();
    t_tie_release();
    t_slave();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule